// File: doc/BRIEF.md
# Segment LCD display RAM controller

This block is the digital core of a multiplexed segment LCD driver with 32 segment lines and up to 4 backplane lines. A bus front end that has already framed the serial wire traffic into bytes hands it start and stop events and each received byte. The block answers only to one fixed write address. The first byte after the address is a command byte. Commands can set the display pointer, the number of active backplanes and the blink rate. When the command phase ends, every further byte is display data, stored through a pointer that moves forward on its own.

A scanner drives one backplane at a time. It moves to the next backplane on each frame tick. On the segment lines it shows the stored on/off bits for the active backplane. An optional blinker blanks all segments for alternate periods, counted in frame ticks. Bias voltages, level selection and the bit-level bus interface sit outside this block.

Top module: `seglcd_core`

## Requirements
- R1: An address byte of 0x70 (7-bit address 0x38, write bit 0) that follows a start is acknowledged. So is every later byte up to the next stop or start. `bus_ack` is high for exactly the one cycle after the byte's valid cycle, and is low after any cycle with no valid byte.
- R2: An address byte other than 0x70, including the read form 0x71, gets no acknowledge. The bytes that follow it up to the next start get no acknowledge and leave the display unchanged.
- R3: The byte after the address is a command. Bit 7 = 1 means another command follows; bit 7 = 0 means data follows. Bits 6:5 select the operation: 00 loads the segment pointer from bits 4:0, 01 sets the backplane count to bits 1:0 plus one, 10 sets the blink code from bits 1:0, and 11 has no effect.
- R4: A data byte writes 8 display bits starting at the pointer. Bits 7..4 go to backplanes 0..3 of the segment at the pointer. Bits 3..0 go to backplanes 0..3 of the next segment. The pointer then moves forward two segments.
- R5: The pointer wraps from segment 31 to segment 0, including within a single data byte.
- R6: `bp_out` is one-hot and shows the active backplane. It changes only on a frame tick or a backplane-count command. It steps 0,1,... and returns to 0 after the last enabled backplane. `seg_out[s]` is the stored bit for segment s on the active backplane.
- R7: Backplanes above the programmed count are never driven and stay 0.
- R8: A backplane-count command returns the scan to backplane 0 on the next cycle.
- R9: A blink code c of 1, 2 or 3 blanks all segments, with the blank and visible phases alternating every 4, 8 or 16 frame ticks respectively. Writing a blink command restarts the visible phase. Code 0 never blanks.
- R10: After reset: `bp_out` = 0001, `seg_out` = 0, `bus_ack` = 0, all 4 backplanes enabled, blink off.
- R11: A byte with no preceding start, or one that arrives after a stop, is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle start (or repeated start) event |
| bus_stop | input | 1 | One-cycle stop event |
| bus_byte_vld | input | 1 | One-cycle strobe: a received byte is present |
| bus_byte | input | 8 | Received byte |
| frame_tick | input | 1 | One-cycle tick that advances the backplane scan |
| bus_ack | output | 1 | Acknowledge for the byte received one cycle earlier |
| seg_out | output | 32 | Segment on/off pattern for the active backplane |
| bp_out | output | 4 | One-hot active backplane |

## Verification
The assertions assume that start, stop and byte-valid never coincide in one cycle, and that each lasts a single cycle. They also assume that a frame tick is not given in the same cycle as a backplane-count command. The bench drives every bus event as a one-cycle pulse on its own clock and keeps frame ticks apart from bus bytes. A cycle-level model in the bench follows the pointer, the backplane count, the scan position and the blink tick count. The bench checks the acknowledge after each byte and compares both output buses after every tick.

// File: rtl/seglcd_pkg.sv
package seglcd_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_CMD,
        RX_DATA,
        RX_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        OP_PTR   = 2'b00,
        OP_MODE  = 2'b01,
        OP_BLINK = 2'b10,
        OP_RSVD  = 2'b11
    } cmd_op_e;

    typedef struct packed {
        rx_state_e st;
        logic      ack;
    } rx_regs_t;

endpackage

// File: rtl/seglcd_bus_rx.sv
module seglcd_bus_rx
    import seglcd_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h38,
    parameter int         PTR_W      = 5,
    parameter int         BP_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             vld,
    input  logic [7:0]       byte_in,
    output logic             ack,
    output logic             ptr_ld,
    output logic [PTR_W-1:0] ptr_val,
    output logic             dat_wr,
    output logic [7:0]       dat,
    output logic             mode_ld,
    output logic [BP_W-1:0]  mode_val,
    output logic             blink_ld,
    output logic [1:0]       blink_val
);

    localparam logic [7:0] WR_ADDR = {SLAVE_ADDR, 1'b0};

    rx_regs_t q, d;

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        ptr_ld    = 1'b0;
        dat_wr    = 1'b0;
        mode_ld   = 1'b0;
        blink_ld  = 1'b0;
        ptr_val   = byte_in[PTR_W-1:0];
        dat       = byte_in;
        mode_val  = byte_in[BP_W-1:0];
        blink_val = byte_in[1:0];
        if (start) begin
            d.st = RX_ADDR;
        end else if (stop) begin
            d.st = RX_IDLE;
        end else if (vld) begin
            case (q.st)
                RX_ADDR: begin
                    if (byte_in == WR_ADDR) begin
                        d.ack = 1'b1;
                        d.st  = RX_CMD;
                    end else begin
                        d.st  = RX_SKIP;
                    end
                end
                RX_CMD: begin
                    d.ack = 1'b1;
                    case (cmd_op_e'(byte_in[6:5]))
                        OP_PTR:   ptr_ld   = 1'b1;
                        OP_MODE:  mode_ld  = 1'b1;
                        OP_BLINK: blink_ld = 1'b1;
                        default:  ;
                    endcase
                    if (!byte_in[7]) d.st = RX_DATA;
                end
                RX_DATA: begin
                    d.ack  = 1'b1;
                    dat_wr = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, ack: 1'b0};
        else        q <= d;
    end

    assign ack = q.ack;

endmodule

// File: rtl/seglcd_ram.sv
module seglcd_ram #(
    parameter int NUM_SEG = 32,
    parameter int NUM_BP  = 4,
    parameter int PTR_W   = 5,
    parameter int BP_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ptr_ld,
    input  logic [PTR_W-1:0]   ptr_val,
    input  logic               dat_wr,
    input  logic [7:0]         dat,
    input  logic [BP_W-1:0]    scan_bp,
    output logic [NUM_SEG-1:0] col
);

    localparam int RAM_BITS = NUM_SEG * NUM_BP;
    localparam int BIT_W    = $clog2(RAM_BITS);

    typedef struct packed {
        logic [RAM_BITS-1:0] bits;
        logic [BIT_W-1:0]    ptr;
    } ram_regs_t;

    ram_regs_t q, d;

    always_comb begin
        d = q;
        if (ptr_ld) begin
            d.ptr = BIT_W'(ptr_val * NUM_BP);
        end else if (dat_wr) begin
            for (int i = 0; i < 8; i++) begin
                d.bits[q.ptr + BIT_W'(i)] = dat[7-i];
            end
            d.ptr = q.ptr + BIT_W'(8);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_col
        localparam logic [BIT_W-1:0] BASE = BIT_W'(s * NUM_BP);
        assign col[s] = q.bits[BASE + BIT_W'(scan_bp)];
    end

endmodule

// File: rtl/seglcd_scan.sv
module seglcd_scan #(
    parameter int NUM_BP     = 4,
    parameter int BP_W       = 2,
    parameter int BLINK_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              mode_ld,
    input  logic [BP_W-1:0]   mode_val,
    input  logic              blink_ld,
    input  logic [1:0]        blink_val,
    output logic [BP_W-1:0]   scan_bp,
    output logic [NUM_BP-1:0] bp_out,
    output logic [BP_W-1:0]   mux_code,
    output logic              blank
);

    localparam int CNT_W = $clog2(4 * BLINK_BASE + 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(BLINK_BASE - 1);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(2 * BLINK_BASE - 1);
    localparam logic [CNT_W-1:0] LIM3 = CNT_W'(4 * BLINK_BASE - 1);

    typedef struct packed {
        logic [BP_W-1:0]  scan;
        logic [BP_W-1:0]  last;
        logic [1:0]       bcode;
        logic [CNT_W-1:0] cnt;
        logic             blank;
    } scan_regs_t;

    scan_regs_t q, d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        case (q.bcode)
            2'd1:    lim = LIM1;
            2'd2:    lim = LIM2;
            default: lim = LIM3;
        endcase
        d = q;
        if (mode_ld) begin
            d.last = mode_val;
            d.scan = '0;
        end else if (frame_tick) begin
            d.scan = (q.scan == q.last) ? '0 : q.scan + 1'b1;
        end
        if (blink_ld) begin
            d.bcode = blink_val;
            d.cnt   = '0;
            d.blank = 1'b0;
        end else if (frame_tick && q.bcode != 2'd0) begin
            if (q.cnt == lim) begin
                d.cnt   = '0;
                d.blank = ~q.blank;
            end else begin
                d.cnt   = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scan: '0, last: BP_W'(NUM_BP - 1), bcode: 2'd0,
                           cnt: '0, blank: 1'b0};
        else        q <= d;
    end

    for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
        assign bp_out[b] = (q.scan == BP_W'(b));
    end

    assign scan_bp  = q.scan;
    assign mux_code = q.last;
    assign blank    = q.blank;

endmodule

// File: rtl/seglcd_core.sv
module seglcd_core #(
    parameter int         NUM_SEG    = 32,
    parameter int         NUM_BP     = 4,
    parameter logic [6:0] SLAVE_ADDR = 7'h38,
    parameter int         BLINK_BASE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic               bus_byte_vld,
    input  logic [7:0]         bus_byte,
    input  logic               frame_tick,
    output logic               bus_ack,
    output logic [NUM_SEG-1:0] seg_out,
    output logic [NUM_BP-1:0]  bp_out
);

    localparam int PTR_W = $clog2(NUM_SEG);
    localparam int BP_W  = $clog2(NUM_BP);

    logic             ptr_ld, dat_wr, mode_ld, blink_ld, blank;
    logic [PTR_W-1:0] ptr_val;
    logic [7:0]       dat;
    logic [BP_W-1:0]  mode_val, scan_bp, mux_code;
    logic [1:0]       blink_val;
    logic [NUM_SEG-1:0] col;

    seglcd_bus_rx #(.SLAVE_ADDR(SLAVE_ADDR), .PTR_W(PTR_W), .BP_W(BP_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .stop(bus_stop),
        .vld(bus_byte_vld), .byte_in(bus_byte), .ack(bus_ack),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .dat_wr(dat_wr), .dat(dat),
        .mode_ld(mode_ld), .mode_val(mode_val),
        .blink_ld(blink_ld), .blink_val(blink_val)
    );

    seglcd_ram #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP), .PTR_W(PTR_W), .BP_W(BP_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .dat_wr(dat_wr), .dat(dat), .scan_bp(scan_bp), .col(col)
    );

    seglcd_scan #(.NUM_BP(NUM_BP), .BP_W(BP_W), .BLINK_BASE(BLINK_BASE)) u_scan (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .mode_ld(mode_ld), .mode_val(mode_val),
        .blink_ld(blink_ld), .blink_val(blink_val),
        .scan_bp(scan_bp), .bp_out(bp_out), .mux_code(mux_code), .blank(blank)
    );

    assign seg_out = blank ? '0 : col;

endmodule

// File: rtl/seglcd_chk.sv
module seglcd_chk #(
    parameter int NUM_SEG = 32,
    parameter int NUM_BP  = 4,
    parameter int BP_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_byte_vld,
    input logic               bus_ack,
    input logic               frame_tick,
    input logic               mode_ld,
    input logic [NUM_BP-1:0]  bp_out,
    input logic [NUM_SEG-1:0] seg_out,
    input logic [BP_W-1:0]    mux_code,
    input logic               blank
);

    // R6
    bp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bp_out) == 1);

    // R7
    unused_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_out >> (32'(mux_code) + 1)) == '0);

    // R6
    bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !mode_ld) |=> $stable(bp_out));

    // R8
    mode_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ld |=> bp_out[0]);

    // R1
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_byte_vld |=> !bus_ack);

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> seg_out == '0);

endmodule

bind seglcd_core seglcd_chk #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP), .BP_W(BP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_byte_vld(bus_byte_vld), .bus_ack(bus_ack),
    .frame_tick(frame_tick), .mode_ld(mode_ld), .bp_out(bp_out),
    .seg_out(seg_out), .mux_code(mux_code), .blank(blank)
);

// File: tb/sim_seglcd_core.sv
`timescale 1ns/1ps
module sim_seglcd_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, bus_byte_vld = 1'b0;
    logic [7:0]  bus_byte = 8'h00;
    logic        frame_tick = 1'b0;
    logic        bus_ack;
    logic [31:0] seg_out;
    logic [3:0]  bp_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // bench model of the display state
    logic [127:0] m_ram = '0;
    int m_ptr = 0, m_last = 3, m_scan = 0, m_bcode = 0, m_ticks = 0;

    always #2.5 clk = ~clk;

    seglcd_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .frame_tick(frame_tick),
        .bus_ack(bus_ack), .seg_out(seg_out), .bp_out(bp_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_evt(input bit st);
        @(negedge clk);
        if (st) bus_start = 1'b1; else bus_stop = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        bus_stop  = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk);
        bus_byte_vld = 1'b1;
        bus_byte     = b;
        @(negedge clk);
        bus_byte_vld = 1'b0;
        chk(bus_ack == exp_ack, req, 32'(bus_ack), 32'(exp_ack));
    endtask

    task automatic model_data(input logic [7:0] b);
        for (int i = 0; i < 8; i++) m_ram[(m_ptr + i) % 128] = b[7-i];
        m_ptr = (m_ptr + 8) % 128;
    endtask

    task automatic check_out(input string req);
        logic [31:0] es;
        int half;
        bit blk;
        half = 4 << (m_bcode > 0 ? m_bcode - 1 : 0);
        blk  = (m_bcode != 0) && (((m_ticks / half) % 2) == 1);
        for (int s = 0; s < 32; s++) es[s] = m_ram[s*4 + m_scan];
        if (blk) es = '0;
        chk(bp_out == 4'(1 << m_scan), req, 32'(bp_out), 32'(1 << m_scan));
        chk(seg_out == es, req, seg_out, es);
    endtask

    task automatic do_tick();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        m_scan  = (m_scan == m_last) ? 0 : m_scan + 1;
        m_ticks++;
    endtask

    task automatic frame_scan(input string req);
        for (int k = 0; k < 4; k++) begin
            check_out(req);
            do_tick();
        end
        check_out(req);
    endtask

    task automatic t_reset();
        chk(bp_out == 4'b0001, "R10 bp", 32'(bp_out), 32'h1);
        chk(seg_out == '0, "R10 seg", seg_out, 32'h0);
        chk(bus_ack == 1'b0, "R10 ack", 32'(bus_ack), 32'h0);
        frame_scan("R10 four backplanes");
    endtask

    task automatic t_basic();
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'h02, 1'b1, "R3 pointer cmd");
        m_ptr = 2 * 4;
        send_byte(8'hA5, 1'b1, "R1 data ack");
        model_data(8'hA5);
        send_byte(8'h3C, 1'b1, "R4 data ack");
        model_data(8'h3C);
        bus_evt(1'b0);
        frame_scan("R4 R6 display");
    endtask

    task automatic t_wrap();
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'h1F, 1'b1, "R3 pointer 31");
        m_ptr = 31 * 4;
        send_byte(8'hC3, 1'b1, "R5 data");
        model_data(8'hC3);
        send_byte(8'h81, 1'b1, "R5 data");
        model_data(8'h81);
        bus_evt(1'b0);
        frame_scan("R5 wrap");
    endtask

    task automatic t_read();
        bus_evt(1'b1);
        send_byte(8'h71, 1'b0, "R2 read addr");
        send_byte(8'h00, 1'b0, "R2 after read");
        send_byte(8'hFF, 1'b0, "R2 after read");
        bus_evt(1'b0);
        bus_evt(1'b1);
        send_byte(8'h74, 1'b0, "R2 other addr");
        send_byte(8'h00, 1'b0, "R2 after other");
        send_byte(8'hFF, 1'b0, "R2 after other");
        bus_evt(1'b0);
        frame_scan("R2 display unchanged");
    endtask

    task automatic t_nostart();
        send_byte(8'h70, 1'b0, "R11 no start");
        send_byte(8'h00, 1'b0, "R11 no start");
        send_byte(8'hFF, 1'b0, "R11 no start");
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'h00, 1'b1, "R3 pointer 0");
        m_ptr = 0;
        bus_evt(1'b0);
        send_byte(8'hFF, 1'b0, "R11 after stop");
        frame_scan("R11 display unchanged");
    endtask

    task automatic t_chain();
        do_tick();
        check_out("R6 before mode");
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'hA1, 1'b1, "R3 mode 2 continue");
        m_last = 1;
        m_scan = 0;
        chk(bp_out == 4'b0001, "R8 scan home", 32'(bp_out), 32'h1);
        send_byte(8'hE0, 1'b1, "R3 reserved continue");
        send_byte(8'h05, 1'b1, "R3 pointer 5 last");
        m_ptr = 5 * 4;
        send_byte(8'h96, 1'b1, "R4 data");
        model_data(8'h96);
        bus_evt(1'b0);
        for (int k = 0; k < 5; k++) begin
            check_out("R6 two backplanes");
            chk(bp_out[3:2] == 2'b00, "R7 unused low", 32'(bp_out), 32'(1 << m_scan));
            do_tick();
        end
    endtask

    task automatic t_blink();
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'hA3, 1'b1, "R3 mode 4 continue");
        m_last = 3;
        m_scan = 0;
        send_byte(8'h41, 1'b1, "R3 blink 1");
        m_bcode = 1;
        m_ticks = 0;
        bus_evt(1'b0);
        for (int k = 0; k < 10; k++) begin
            check_out("R9 blink code 1");
            do_tick();
        end
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'h42, 1'b1, "R3 blink 2");
        m_bcode = 2;
        m_ticks = 0;
        bus_evt(1'b0);
        for (int k = 0; k < 18; k++) begin
            check_out("R9 blink code 2");
            do_tick();
        end
        bus_evt(1'b1);
        send_byte(8'h70, 1'b1, "R1 address");
        send_byte(8'h40, 1'b1, "R3 blink off");
        m_bcode = 0;
        bus_evt(1'b0);
        for (int k = 0; k < 6; k++) begin
            check_out("R9 blink off");
            do_tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_read();
        t_nostart();
        t_chain();
        t_blink();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule